// File: doc/BRIEF.md
# Transfer Descriptor Retry Error Tracker

This block keeps the status of one USB host transfer descriptor up to date as bus transactions finish. At each end-of-transaction strobe it takes the descriptor token fields as they stand: a 2-bit retry budget, the PID code, the active and halted flags, and the endpoint speed. It also takes the outcome of the transaction, the schedule type and the error-interrupt enable. In one clock edge it registers the values to write back: the new retry budget, the active and halted flags, four sticky error status bits, the token byte for the PID code, a reserved-PID flag and an interrupt request.

Only transaction errors spend the retry budget. A budget preset to zero means retries never run out. A clean completion refills the budget to full only when the endpoint is high-speed or the descriptor is on the asynchronous schedule, and only when the PID code is IN or OUT. Stalls and babble halt the descriptor at once. Buffer errors count as host faults and are recorded without spending a retry.

Top module: `qtd_retry_tracker`

## Requirements
- R1: On a strobe with the descriptor active, outcome 001 (transaction error) and a non-zero budget, the budget drops by one and status bit 0 is set. If the new budget is non-zero, the descriptor stays active.
- R2: When a transaction error takes the budget from 1 to 0, the descriptor becomes inactive, halted is set and status bit 0 is set.
- R3: The interrupt output is high after a strobe only if that strobe caused the 1-to-0 halt of R2 while the error-interrupt enable was high. After every other strobe that is processed, it is low.
- R4: A budget of 0 at the strobe stays 0 for every outcome, and a transaction error does not halt the descriptor.
- R5: Outcome 010 (data buffer error) sets status bit 1 and leaves the budget and the active flag unchanged.
- R6: Outcome 011 (stall) sets status bit 2 and outcome 100 (babble) sets status bit 3. Either one makes the descriptor inactive and halted and leaves the budget unchanged.
- R7: Outcome 000 (success) refills the budget to 11 only if all three hold: the budget is non-zero, the PID code is 00 or 01, and either the high-speed input or the async-schedule input is high. Otherwise the budget is unchanged.
- R8: The token byte is E1h for PID code 00 (OUT), 69h for 01 (IN) and 2Dh for 10 (SETUP). In each of these cases the token-valid output is high and the PID error output is low.
- R9: PID code 11 sets the PID error output, clears token-valid and gives token byte 00h.
- R10: A strobe that arrives while the active input is low changes no output.
- R11: The status bits (bit 0 transaction error, bit 1 buffer error, bit 2 stall, bit 3 babble) only accumulate from strobe to strobe. Between strobes no output changes. A synchronous reset sets every output to zero.
- R12: Outcome codes 101 to 111 leave the budget and the flags as presented and set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_done | input | 1 | End-of-transaction strobe |
| cnt_in | input | 2 | Retry budget at the start of the transaction |
| pid_in | input | 2 | PID code |
| active_in | input | 1 | Descriptor active flag |
| halted_in | input | 1 | Descriptor halted flag |
| hs_ep | input | 1 | Endpoint is high-speed |
| async_sched | input | 1 | Descriptor is on the asynchronous schedule |
| outcome | input | 3 | Transaction outcome code |
| err_irq_en | input | 1 | Error interrupt enable |
| cnt_q | output | 2 | Updated retry budget |
| active_q | output | 1 | Updated active flag |
| halted_q | output | 1 | Updated halted flag |
| status_q | output | 4 | Sticky error status bits |
| token_q | output | 8 | Token byte for the PID code |
| token_vld | output | 1 | Token byte is valid |
| pid_err | output | 1 | Reserved PID code seen |
| irq | output | 1 | Error interrupt request |

## Verification
Every result sits exactly one clock edge behind the strobe. The edge that samples a high xfer_done also loads all outputs, and they then hold until the next processed strobe. The monitor therefore samples 1 ns after each rising edge at which the strobe was high, and compares against the scoreboard entry the driver pushed for that strobe. After an edge with no strobe it checks that the outputs still equal the last result.

// File: rtl/qtd_pkg.sv
package qtd_pkg;
    parameter int unsigned CNT_W = 2;
    parameter int unsigned TOK_W = 8;
    parameter int unsigned ST_W  = 4;

    localparam int unsigned ST_XACT   = 0;
    localparam int unsigned ST_BUF    = 1;
    localparam int unsigned ST_STALL  = 2;
    localparam int unsigned ST_BABBLE = 3;

    typedef enum logic [2:0] {
        OC_OK     = 3'd0,
        OC_XACT   = 3'd1,
        OC_BUF    = 3'd2,
        OC_STALL  = 3'd3,
        OC_BABBLE = 3'd4
    } outcome_e;

    typedef enum logic [1:0] {
        PID_OUT   = 2'd0,
        PID_IN    = 2'd1,
        PID_SETUP = 2'd2,
        PID_RSV   = 2'd3
    } pid_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             halted;
        logic [ST_W-1:0]  status;
        logic [TOK_W-1:0] token;
        logic             tok_vld;
        logic             pid_err;
        logic             irq;
    } qtd_state_t;
endpackage

// File: rtl/qtd_pid_encoder.sv
module qtd_pid_encoder
    import qtd_pkg::*;
(
    input  logic [1:0]       pid,
    output logic [TOK_W-1:0] token,
    output logic             valid
);
    always_comb begin
        valid = 1'b1;
        case (pid)
            PID_OUT:   token = TOK_W'(8'hE1);
            PID_IN:    token = TOK_W'(8'h69);
            PID_SETUP: token = TOK_W'(8'h2D);
            default: begin
                token = '0;
                valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qtd_cerr_update.sv
module qtd_cerr_update
    import qtd_pkg::*;
(
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [2:0]       outcome,
    input  logic [1:0]       pid,
    input  logic             hs_ep,
    input  logic             async_sched,
    output logic [CNT_W-1:0] cnt_next,
    output logic             halt_now,
    output logic             final_dec,
    output logic [ST_W-1:0]  st_set
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = '1;

    logic cnt_zero;
    logic refill_ok;

    assign cnt_zero  = (cnt_in == '0);
    assign refill_ok = !cnt_zero && (pid == PID_OUT || pid == PID_IN)
                       && (hs_ep || async_sched);

    always_comb begin
        cnt_next  = cnt_in;
        halt_now  = 1'b0;
        final_dec = 1'b0;
        st_set    = '0;
        case (outcome)
            OC_XACT: begin
                st_set[ST_XACT] = 1'b1;
                if (!cnt_zero) begin
                    cnt_next = cnt_in - CNT_ONE;
                    if (cnt_in == CNT_ONE) begin
                        final_dec = 1'b1;
                        halt_now  = 1'b1;
                    end
                end
            end
            OC_BUF:    st_set[ST_BUF] = 1'b1;
            OC_STALL: begin
                st_set[ST_STALL] = 1'b1;
                halt_now         = 1'b1;
            end
            OC_BABBLE: begin
                st_set[ST_BABBLE] = 1'b1;
                halt_now          = 1'b1;
            end
            OC_OK: begin
                if (refill_ok) cnt_next = CNT_FULL;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qtd_retry_tracker.sv
module qtd_retry_tracker
    import qtd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_done,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [1:0]       pid_in,
    input  logic             active_in,
    input  logic             halted_in,
    input  logic             hs_ep,
    input  logic             async_sched,
    input  logic [2:0]       outcome,
    input  logic             err_irq_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             active_q,
    output logic             halted_q,
    output logic [ST_W-1:0]  status_q,
    output logic [TOK_W-1:0] token_q,
    output logic             token_vld,
    output logic             pid_err,
    output logic             irq
);
    qtd_state_t st_d, st_q;

    logic [CNT_W-1:0] cnt_next;
    logic             halt_now;
    logic             final_dec;
    logic [ST_W-1:0]  st_set;
    logic [TOK_W-1:0] tok;
    logic             tok_ok;

    qtd_pid_encoder u_pid (
        .pid   (pid_in),
        .token (tok),
        .valid (tok_ok)
    );

    qtd_cerr_update u_cerr (
        .cnt_in      (cnt_in),
        .outcome     (outcome),
        .pid         (pid_in),
        .hs_ep       (hs_ep),
        .async_sched (async_sched),
        .cnt_next    (cnt_next),
        .halt_now    (halt_now),
        .final_dec   (final_dec),
        .st_set      (st_set)
    );

    always_comb begin
        st_d = st_q;
        if (xfer_done && active_in) begin
            st_d.cnt     = cnt_next;
            st_d.active  = !halt_now;
            st_d.halted  = halted_in || halt_now;
            st_d.status  = st_q.status | st_set;
            st_d.token   = tok;
            st_d.tok_vld = tok_ok;
            st_d.pid_err = !tok_ok;
            st_d.irq     = final_dec && err_irq_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_q     = st_q.cnt;
    assign active_q  = st_q.active;
    assign halted_q  = st_q.halted;
    assign status_q  = st_q.status;
    assign token_q   = st_q.token;
    assign token_vld = st_q.tok_vld;
    assign pid_err   = st_q.pid_err;
    assign irq       = st_q.irq;
endmodule

// File: rtl/qtd_retry_tracker_chk.sv
module qtd_retry_tracker_chk
    import qtd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             xfer_done,
    input logic [CNT_W-1:0] cnt_in,
    input logic [1:0]       pid_in,
    input logic             active_in,
    input logic             halted_in,
    input logic             hs_ep,
    input logic             async_sched,
    input logic [2:0]       outcome,
    input logic             err_irq_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic             active_q,
    input logic             halted_q,
    input logic [ST_W-1:0]  status_q,
    input logic [TOK_W-1:0] token_q,
    input logic             token_vld,
    input logic             pid_err,
    input logic             irq
);
    logic go;
    assign go = xfer_done && active_in;

    a_r2_final_halt: assert property (@(posedge clk) disable iff (rst)
        (go && outcome == OC_XACT && cnt_in == CNT_W'(1))
        |=> (cnt_q == '0 && !active_q && halted_q && status_q[ST_XACT]));

    a_r3_irq_cause: assert property (@(posedge clk) disable iff (rst)
        (go && !(outcome == OC_XACT && cnt_in == CNT_W'(1))) |=> !irq);

    a_r4_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (go && cnt_in == '0) |=> (cnt_q == '0));

    a_r5_buf_no_dec: assert property (@(posedge clk) disable iff (rst)
        (go && outcome == OC_BUF) |=> (cnt_q == $past(cnt_in) && status_q[ST_BUF]));

    a_r6_stall_halts: assert property (@(posedge clk) disable iff (rst)
        (go && (outcome == OC_STALL || outcome == OC_BABBLE))
        |=> (!active_q && halted_q && cnt_q == $past(cnt_in)));

    a_r9_rsv_pid: assert property (@(posedge clk) disable iff (rst)
        (go && pid_in == PID_RSV) |=> (pid_err && !token_vld));

    a_r10_inactive_ignored: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !active_in)
        |=> ($stable(cnt_q) && $stable(active_q) && $stable(status_q) && $stable(irq)));

    a_r11_hold_between: assert property (@(posedge clk) disable iff (rst)
        !xfer_done |=> ($stable(cnt_q) && $stable(halted_q) && $stable(token_q)));
endmodule

bind qtd_retry_tracker qtd_retry_tracker_chk chk_i (.*);

// File: tb/qtd_retry_tracker_tb_top.sv
module qtd_retry_tracker_tb_top;
    import qtd_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xfer_done = 1'b0;
    logic [1:0] cnt_in = '0;
    logic [1:0] pid_in = '0;
    logic active_in = 1'b0, halted_in = 1'b0, hs_ep = 1'b0, async_sched = 1'b0;
    logic [2:0] outcome = '0;
    logic err_irq_en = 1'b0;
    logic [1:0] cnt_q;
    logic active_q, halted_q, token_vld, pid_err, irq;
    logic [3:0] status_q;
    logic [7:0] token_q;

    int checks = 0;
    int errors = 0;

    qtd_state_t model, last;
    qtd_state_t exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    qtd_retry_tracker dut_i (.*);

    function automatic qtd_state_t observed();
        qtd_state_t o;
        o.cnt = cnt_q; o.active = active_q; o.halted = halted_q;
        o.status = status_q; o.token = token_q; o.tok_vld = token_vld;
        o.pid_err = pid_err; o.irq = irq;
        return o;
    endfunction

    task automatic compare(qtd_state_t exp, string tag);
        qtd_state_t act = observed();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: results are due one edge after the strobe.
    always @(posedge clk) begin
        if (!rst) begin
            if (xfer_done) begin
                #1;
                if (exp_q.size() > 0) begin
                    last = exp_q.pop_front();
                    compare(last, tag_q.pop_front());
                end
            end else begin
                #1;
                compare(last, "R11 hold between strobes");
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        compare('0, "R11 reset clears outputs");
        model = '0;
        last  = '0;
        rst = 1'b0;
    endtask

    task automatic strobe(input logic [1:0] c, input logic [1:0] p, input logic a,
                          input logic h, input logic hs, input logic as,
                          input logic [2:0] oc, input logic ien, input string tag);
        @(negedge clk);
        cnt_in = c; pid_in = p; active_in = a; halted_in = h;
        hs_ep = hs; async_sched = as; outcome = oc; err_irq_en = ien;
        xfer_done = 1'b1;
        if (a) begin
            model.cnt = c; model.active = 1'b1; model.halted = h; model.irq = 1'b0;
            case (p)
                2'd0: model.token = 8'hE1;
                2'd1: model.token = 8'h69;
                2'd2: model.token = 8'h2D;
                default: model.token = 8'h00;
            endcase
            model.tok_vld = (p != 2'd3);
            model.pid_err = (p == 2'd3);
            if (oc == 3'd1) begin
                model.status[0] = 1'b1;
                if (c != 0) model.cnt = c - 2'd1;
                if (c == 2'd1) begin
                    model.active = 1'b0; model.halted = 1'b1; model.irq = ien;
                end
            end else if (oc == 3'd2) begin
                model.status[1] = 1'b1;
            end else if (oc == 3'd3 || oc == 3'd4) begin
                model.status[oc == 3'd3 ? 2 : 3] = 1'b1;
                model.active = 1'b0; model.halted = 1'b1;
            end else if (oc == 3'd0) begin
                if (c != 0 && p <= 2'd1 && (hs || as)) model.cnt = 2'b11;
            end
        end
        exp_q.push_back(model);
        tag_q.push_back(tag);
        @(negedge clk);
        xfer_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model = '0;
        last  = '0;
        do_reset();
        strobe(2'd3, 2'd1, 1, 0, 1, 0, 3'd1, 1, "R1 xact err 3->2");
        strobe(2'd1, 2'd0, 1, 0, 1, 0, 3'd1, 1, "R2 R3 final decrement irq");
        strobe(2'd1, 2'd0, 1, 0, 1, 0, 3'd1, 0, "R3 final decrement irq disabled");
        strobe(2'd0, 2'd1, 1, 0, 0, 0, 3'd1, 1, "R4 zero budget unlimited");
        strobe(2'd0, 2'd1, 1, 0, 1, 1, 3'd0, 0, "R4 R7 zero never refilled");
        do_reset();
        strobe(2'd2, 2'd1, 1, 0, 0, 0, 3'd2, 1, "R5 buffer error");
        strobe(2'd2, 2'd0, 1, 0, 1, 0, 3'd3, 1, "R6 stall");
        strobe(2'd2, 2'd1, 1, 0, 1, 0, 3'd4, 1, "R6 babble");
        strobe(2'd1, 2'd1, 1, 0, 1, 0, 3'd0, 0, "R7 refill hs IN");
        strobe(2'd1, 2'd0, 1, 0, 0, 1, 3'd0, 0, "R7 refill async OUT");
        strobe(2'd1, 2'd2, 1, 0, 1, 1, 3'd0, 0, "R7 R8 SETUP no refill");
        strobe(2'd2, 2'd1, 1, 0, 0, 0, 3'd0, 0, "R7 periodic fs no refill");
        strobe(2'd2, 2'd3, 1, 0, 1, 0, 3'd0, 0, "R9 reserved pid");
        strobe(2'd1, 2'd0, 0, 0, 1, 0, 3'd1, 1, "R10 inactive ignored");
        strobe(2'd2, 2'd1, 1, 1, 1, 0, 3'd5, 1, "R12 unknown outcome");
        strobe(2'd3, 2'd0, 1, 0, 0, 1, 3'd7, 0, "R12 unknown outcome 7");
        do_reset();
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule